// File: doc/BRIEF.md
# Crest-Factor Overcurrent Detector

This block watches digitised samples of the low-side switch current of a resonant half-bridge and decides when the current waveform has become too peaky. Such a waveform is the sign of a saturating resonant inductor. The sensing element is the low-side switch's own on-resistance, so only samples taken while that switch conducts mean anything. The block has no absolute current limit. It keeps the highest sample of each conduction window and a running exponential average of all accepted samples. It trips when the peak is more than 5.5 times the average. A change of on-resistance with temperature or from part to part scales both quantities by the same factor, so the decision does not depend on it.

The mode controller drives `enable` high only while the lamp is in regulated dimming operation. During preheat and ignition `enable` stays low. Raising `enable` starts a fresh history. Once the detector has seen `MIN_SAMPLES` accepted samples, it compares the peak against the average once per window, when the conduction window closes. A trip latches `fault`, which the mode controller uses to enter its latched shutdown state. `fault` clears only on reset or when `enable` falls.

A four-state machine sequences the block:
- `ST_OFF`: detection is disabled and all history is cleared.
- `ST_WARMUP`: the average is filling.
- `ST_ARMED`: the block compares at each window close.
- `ST_TRIPPED`: the fault is latched.

The machine has these transitions:
- OFF→WARMUP: enable rises.
- WARMUP→ARMED: the accepted-sample count reaches `MIN_SAMPLES`.
- ARMED→TRIPPED: a window closes with the ratio exceeded.
- Any state→OFF: enable is low.

Top module: `crest_fault_detector`

## Requirements
- R1: A sample is accepted only in a cycle where `enable`, `sample_valid` and `lo_window` are all 1. Samples offered with `lo_window`=0 or `enable`=0 change neither the peak, the average nor the sample count.
- R2: The peak restarts in the first cycle of each conduction window (`lo_window` 0→1). It then holds the largest sample accepted in that window, so a large sample from an earlier window cannot cause a trip.
- R3: The average is `acc >> AVG_SHIFT`. The first sample accepted after `enable` rises loads `acc = s << AVG_SHIFT`. Every later accepted sample updates `acc = acc - (acc >> AVG_SHIFT) + s`.
- R4: The trip condition is `2*peak > 11*avg`, a strict comparison with integer average. It is evaluated only in the cycle where `lo_window` goes 1→0, and `fault` reads 1 from the following cycle.
- R5: No trip is possible until `MIN_SAMPLES` samples have been accepted since `enable` rose.
- R6: While `enable` stays 1, `fault` stays 1 once set, whatever later windows contain.
- R7: When `enable` is 0, `fault` is 0 from the next cycle and all history (peak, average, count) is discarded. Nothing trips while disabled.
- R8: After reset `fault` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Detection enable from the mode controller (dimming mode only) |
| sample_valid | input | 1 | Current sample strobe |
| sample | input | SAMPLE_W | Unsigned low-side current sample |
| lo_window | input | 1 | High while the low-side switch conducts |
| fault | output | 1 | Sticky crest-factor fault flag |

## Verification
The hardest condition to reach is a trip that depends on the exact integer value of the average at the moment a window closes. The spike sample itself moves the average, and the comparison is strict. The stimulus therefore first settles the average on a constant baseline with a full warm-up window. It then closes a window of baseline samples followed by one spike chosen so that `2*peak` lands one below, exactly on, and just above `11*avg`. The peak-restart and ignored-sample cases reuse the same tuned spike values, so that stale state would flip the outcome.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_WARMUP  = 2'd1,
        ST_ARMED   = 2'd2,
        ST_TRIPPED = 2'd3
    } cfd_state_e;

    // Ratio 5.5 written as 11/2 so the comparison stays in integers.
    localparam int RATIO_NUM = 11;
    localparam int RATIO_DEN = 2;

endpackage

// File: rtl/cfd_peak_hold.sv
module cfd_peak_hold #(
    parameter int SAMPLE_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                win_start,
    input  logic                take,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [SAMPLE_W-1:0] peak
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            peak <= '0;
        end else if (flush) begin
            peak <= '0;
        end else if (win_start) begin
            peak <= take ? sample : '0;
        end else if (take && (sample > peak)) begin
            peak <= sample;
        end
    end

endmodule

// File: rtl/cfd_ema_avg.sv
module cfd_ema_avg #(
    parameter int SAMPLE_W  = 10,
    parameter int AVG_SHIFT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                seed,
    input  logic                take,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [SAMPLE_W-1:0] avg
);

    localparam int ACC_W = SAMPLE_W + AVG_SHIFT;

    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   acc_next;

    assign avg = acc[ACC_W-1:AVG_SHIFT];

    always_comb begin
        acc_next = {1'b0, acc}
                 - {{(AVG_SHIFT + 1){1'b0}}, avg}
                 + {{(AVG_SHIFT + 1){1'b0}}, sample};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (flush) begin
            acc <= '0;
        end else if (take) begin
            if (seed) begin
                acc <= {sample, {AVG_SHIFT{1'b0}}};
            end else begin
                acc <= acc_next[ACC_W-1:0];
            end
        end
    end

endmodule

// File: rtl/crest_fault_detector.sv
module crest_fault_detector
    import cfd_pkg::*;
#(
    parameter int SAMPLE_W    = 10,
    parameter int AVG_SHIFT   = 3,
    parameter int MIN_SAMPLES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                lo_window,
    output logic                fault
);

    localparam int CNT_W = $clog2(MIN_SAMPLES + 1);
    localparam int CMP_W = SAMPLE_W + 4;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(MIN_SAMPLES);

    cfd_state_e state, state_nx;

    logic                lo_q;
    logic                win_start;
    logic                win_end;
    logic                take;
    logic [CNT_W-1:0]    sample_cnt;
    logic [SAMPLE_W-1:0] peak;
    logic [SAMPLE_W-1:0] avg;
    logic [CMP_W-1:0]    lhs;
    logic [CMP_W-1:0]    rhs;
    logic                ratio_hit;

    assign take      = enable && sample_valid && lo_window;
    assign win_start = lo_window && !lo_q;
    assign win_end   = !lo_window && lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= 1'b0;
        end else begin
            lo_q <= lo_window;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_cnt <= '0;
        end else if (!enable) begin
            sample_cnt <= '0;
        end else if (take && (sample_cnt != CNT_FULL)) begin
            sample_cnt <= sample_cnt + 1'b1;
        end
    end

    cfd_peak_hold #(
        .SAMPLE_W(SAMPLE_W)
    ) u_peak (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (!enable),
        .win_start(win_start),
        .take     (take),
        .sample   (sample),
        .peak     (peak)
    );

    cfd_ema_avg #(
        .SAMPLE_W (SAMPLE_W),
        .AVG_SHIFT(AVG_SHIFT)
    ) u_avg (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!enable),
        .seed  (sample_cnt == '0),
        .take  (take),
        .sample(sample),
        .avg   (avg)
    );

    // peak * 2 against avg * 11, widened so neither side can wrap.
    always_comb begin
        lhs = CMP_W'(peak) * CMP_W'(RATIO_DEN);
        rhs = CMP_W'(avg) * CMP_W'(RATIO_NUM);
        ratio_hit = lhs > rhs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: begin
                if (enable) state_nx = ST_WARMUP;
            end
            ST_WARMUP: begin
                if (!enable)                       state_nx = ST_OFF;
                else if (sample_cnt == CNT_FULL)   state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (!enable)                       state_nx = ST_OFF;
                else if (win_end && ratio_hit)     state_nx = ST_TRIPPED;
            end
            ST_TRIPPED: begin
                if (!enable) state_nx = ST_OFF;
            end
            default: state_nx = ST_OFF;
        endcase
    end

    always_comb begin
        fault = (state == ST_TRIPPED);
    end

endmodule

// File: rtl/cfd_checker.sv
module cfd_checker #(
    parameter int SAMPLE_W    = 10,
    parameter int CNT_W       = 4,
    parameter int MIN_SAMPLES = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                enable,
    input logic                sample_valid,
    input logic                lo_window,
    input logic [SAMPLE_W-1:0] sample,
    input logic [SAMPLE_W-1:0] peak,
    input logic [CNT_W-1:0]    sample_cnt,
    input logic                fault
);

    p_clear_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !fault);

    p_fault_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && enable) |=> fault);

    p_trip_at_window_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> ($past(lo_window, 2) && !$past(lo_window)));

    p_no_trip_in_warmup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sample_cnt) < MIN_SAMPLES) |-> !fault);

    p_peak_covers_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && sample_valid && lo_window) |=> (peak >= $past(sample)));

endmodule

bind crest_fault_detector cfd_checker #(
    .SAMPLE_W   (SAMPLE_W),
    .CNT_W      (CNT_W),
    .MIN_SAMPLES(MIN_SAMPLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .sample_valid(sample_valid),
    .lo_window   (lo_window),
    .sample      (sample),
    .peak        (peak),
    .sample_cnt  (sample_cnt),
    .fault       (fault)
);

// File: tb/sim_crest_fault_detector.sv
`timescale 1ns/1ps
module sim_crest_fault_detector;

    localparam int SW   = 10;
    localparam int MINS = 8;
    localparam int NVEC = 7;

    // {baseline, spike, expected fault} with AVG_SHIFT = 3:
    // avg after spike = (7*base + spike) >> 3, trip if 2*spike > 11*avg.
    localparam int VEC [NVEC][3] = '{
        '{10, 144, 1},
        '{10, 143, 0},
        '{10, 150, 1},
        '{10, 140, 0},
        '{0,    5, 1},
        '{0,    0, 0},
        '{100, 1000, 0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          sample_valid = 1'b0;
    logic [SW-1:0] sample = '0;
    logic          lo_window = 1'b0;
    logic          fault;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    crest_fault_detector #(
        .SAMPLE_W(SW), .AVG_SHIFT(3), .MIN_SAMPLES(MINS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .sample_valid(sample_valid), .sample(sample),
        .lo_window(lo_window), .fault(fault)
    );

    task automatic check(input string req, input logic exp);
        n_checks++;
        if (fault !== exp) begin
            n_errors++;
            $display("FAIL %s: fault=%0b expected %0b", req, fault, exp);
        end
    endtask

    task automatic push(input int v);
        @(negedge clk);
        sample_valid = 1'b1;
        sample = SW'(v);
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic open_win();
        @(negedge clk);
        lo_window = 1'b1;
    endtask

    task automatic close_win();
        @(negedge clk);
        lo_window = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic restart();
        @(negedge clk);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
    endtask

    task automatic warm(input int base);
        open_win();
        for (int i = 0; i < MINS; i++) push(base);
        close_win();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset", 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 after release", 1'b0);

        // Table walk: R3 average arithmetic and R4 strict ratio boundary.
        for (int k = 0; k < NVEC; k++) begin
            restart();
            warm(VEC[k][0]);
            check("R5 warm-up window", 1'b0);
            open_win();
            for (int i = 0; i < 3; i++) push(VEC[k][0]);
            push(VEC[k][1]);
            repeat (2) @(negedge clk);
            check("R4 no trip before window close", 1'b0);
            close_win();
            check("R3/R4 ratio vector", VEC[k][2] != 0);
        end

        // R6 sticky: trip, then a clean window, fault stays.
        restart();
        warm(10);
        open_win(); push(10); push(144); close_win();
        check("R6 trip", 1'b1);
        open_win(); push(10); push(10); close_win();
        check("R6 sticky after clean window", 1'b1);
        // R7 clear on disable.
        @(negedge clk); enable = 1'b0;
        @(negedge clk);
        check("R7 cleared by disable", 1'b0);

        // R7 disabled: spike windows never trip.
        open_win(); push(0); push(900); close_win();
        open_win(); push(0); push(900); close_win();
        check("R7 no trip while disabled", 1'b0);

        // R1/R5: disabled samples not counted; after enable only 2 samples.
        @(negedge clk); enable = 1'b1;
        open_win(); push(0); push(100); close_win();
        check("R5 trip suppressed during warm-up", 1'b0);

        // R1: samples outside window ignored; avg must stay exactly at 10.
        restart();
        warm(10);
        for (int i = 0; i < 6; i++) push(1000);
        check("R1 no trip from out-of-window samples", 1'b0);
        open_win(); push(10); push(10); push(10); push(144); close_win();
        check("R1 average untouched by out-of-window samples", 1'b1);

        // R2: near-miss spike then a plain window; stale peak would trip.
        restart();
        warm(10);
        open_win(); push(10); push(10); push(10); push(140); close_win();
        check("R2 near-miss window", 1'b0);
        open_win(); for (int i = 0; i < 4; i++) push(10); close_win();
        check("R2 peak restarted per window", 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule